// File: doc/BRIEF.md
# Cross-Lane Permute Unit

This block moves 32-bit values between the 64 lanes of a vector register. A 9-bit control word selects one operation from a single code space. The operations are quad permutes, shifts and rotates within a 16-lane row, one-lane shifts and rotates across the whole wave, row and half-row mirrors, and two broadcasts. Each destination lane works out, in parallel with the other 63, which source lane it reads.

The lanes form 4 rows of 16 lanes, and each row holds 4 banks of 4 lanes. A row mask and a bank mask decide which lanes may be written at all. For an enabled lane whose source does not exist, or whose execute bit is clear, a bound-control bit picks between writing zero and leaving the lane alone. A lane that is not written passes its old destination value through to the result.

The result, the per-lane write enables and an illegal-control flag are registered and appear one cycle after a valid strobe.

Top module: `lane_permute_unit`

## Requirements
- R1: For control values 0x000 to 0x0FF (bit 8 clear), destination lane d reads source lane (d with bits 1:0 cleared) plus control bits [2q+1:2q], where q = d mod 4.
- R2: For control 0x101 to 0x10F, with n = control bits [3:0], row offset k reads offset k+n of the same row, and the source is out of bounds when k+n > 15. For 0x111 to 0x11F, offset k reads offset k-n, and the source is out of bounds when k < n.
- R3: For control 0x121 to 0x12F, with n = control bits [3:0], row offset k reads offset (k-n) mod 16 of the same row, and no source is ever out of bounds.
- R4: For 0x130, lane d reads d+1 and lane 63 is out of bounds. For 0x134, lane d reads (d+1) mod 64. For 0x138, lane d reads d-1 and lane 0 is out of bounds. For 0x13C, lane d reads (d-1) mod 64.
- R5: For 0x140, row offset k reads offset 15-k of the same row. For 0x141, lane d reads position 7-(d mod 8) within its own aligned group of 8 lanes.
- R6: For 0x142, every lane of rows 1 to 3 reads the last lane of the row below it, and row 0 reads itself. For 0x143, lanes 32 to 63 read lane 31, and lanes 0 to 31 read themselves.
- R7: Lane d is disabled when row-mask bit d/16 or bank-mask bit (d mod 16)/4 is 0. A disabled lane has its write enable low whatever the other inputs are.
- R8: For an enabled lane with an out-of-bounds source or a clear execute bit, bound control 1 writes zero with the enable high, and bound control 0 leaves the enable low.
- R9: Control 0x100, 0x110, 0x120, any 0x13x value other than 0x130/0x134/0x138/0x13C, and any value of 0x144 or above raise the illegal flag and force every write enable low.
- R10: Outputs are registered: an accepted strobe shows on the outputs in the next cycle. A cycle without a strobe gives all enables low and the flag low, and the result holds. Reset clears the result, the enables and the flag.
- R11: For each lane whose enable is low, the result carries that lane's old destination value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs in this cycle are taken |
| ctrl | input | 9 | Permute control code |
| row_mask | input | 4 | One enable bit per 16-lane row |
| bank_mask | input | 4 | One enable bit per 4-lane bank within a row |
| bound_ctrl | input | 1 | 1: invalid source writes zero; 0: lane left unwritten |
| exec_mask | input | 64 | Per-lane execute bits |
| src_vec | input | 2048 | Source vector, lane i at bits [32i+31:32i] |
| old_vec | input | 2048 | Old destination vector, same layout |
| result_vec | output | 2048 | Registered result vector |
| result_we | output | 64 | Registered per-lane write enables |
| ctrl_illegal | output | 1 | Registered illegal-control flag |

## Verification
Each operation family is driven with random lane data, a random execute mask, random masks and a random bound-control bit. Every lane is then compared against a bench model of the source lane, so a wrong direction, amount or wrap shows up as a data mismatch in specific lanes. Directed vectors isolate the cases where these features interact. All-ones masks with a full execute mask check pure routing. Shifts by 15 and the wave edges with bound control 0 and 1 separate writing zero from leaving a lane unwritten. Zero masks and reserved codes show that no enable can leak. An idle cycle after a strobe shows that the result holds and the enables drop.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

  typedef enum logic [3:0] {
    OP_QUAD      = 4'd0,
    OP_ROW_UP    = 4'd1,
    OP_ROW_DOWN  = 4'd2,
    OP_ROW_ROT   = 4'd3,
    OP_WAVE_UP   = 4'd4,
    OP_WAVE_RUP  = 4'd5,
    OP_WAVE_DN   = 4'd6,
    OP_WAVE_RDN  = 4'd7,
    OP_MIRROR16  = 4'd8,
    OP_MIRROR8   = 4'd9,
    OP_BC_ROW    = 4'd10,
    OP_BC_HALF   = 4'd11,
    OP_BAD       = 4'd12
  } lpu_op_e;

  // code families within the upper half of the control space (bit 8 set)
  localparam logic [3:0] FAM_ROW_UP   = 4'h0;
  localparam logic [3:0] FAM_ROW_DOWN = 4'h1;
  localparam logic [3:0] FAM_ROW_ROT  = 4'h2;
  localparam logic [3:0] FAM_WAVE     = 4'h3;
  localparam logic [3:0] FAM_MISC     = 4'h4;

endpackage

// File: rtl/lpu_decode.sv
module lpu_decode
  import lpu_pkg::*;
(
  input  logic [8:0] ctrl,
  output lpu_op_e    op,
  output logic [3:0] amount,
  output logic [7:0] quad_sel,
  output logic       illegal
);

  logic [3:0] fam;
  logic [3:0] low;

  assign fam      = ctrl[7:4];
  assign low      = ctrl[3:0];
  assign amount   = low;
  assign quad_sel = ctrl[7:0];

  always_comb begin
    op = OP_BAD;
    if (!ctrl[8]) begin
      op = OP_QUAD;
    end else begin
      unique case (fam)
        FAM_ROW_UP:   op = (low != 4'd0) ? OP_ROW_UP   : OP_BAD;
        FAM_ROW_DOWN: op = (low != 4'd0) ? OP_ROW_DOWN : OP_BAD;
        FAM_ROW_ROT:  op = (low != 4'd0) ? OP_ROW_ROT  : OP_BAD;
        FAM_WAVE: begin
          case (low)
            4'h0:    op = OP_WAVE_UP;
            4'h4:    op = OP_WAVE_RUP;
            4'h8:    op = OP_WAVE_DN;
            4'hC:    op = OP_WAVE_RDN;
            default: op = OP_BAD;
          endcase
        end
        FAM_MISC: begin
          case (low)
            4'h0:    op = OP_MIRROR16;
            4'h1:    op = OP_MIRROR8;
            4'h2:    op = OP_BC_ROW;
            4'h3:    op = OP_BC_HALF;
            default: op = OP_BAD;
          endcase
        end
        default: op = OP_BAD;
      endcase
    end
  end

  assign illegal = (op == OP_BAD);

endmodule

// File: rtl/lpu_lane_sel.sv
module lpu_lane_sel
  import lpu_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int WIDTH     = 32,
  parameter int LANE      = 0
) (
  input  lpu_op_e                  op,
  input  logic [3:0]               amount,
  input  logic [7:0]               quad_sel,
  input  logic [LANES*WIDTH-1:0]   src_vec,
  output logic                     oob,
  output logic [WIDTH-1:0]         data
);

  localparam int IDX_W    = $clog2(LANES);
  localparam int ROW_IDX  = LANE / ROW_LANES;
  localparam int ROW_BASE = ROW_IDX * ROW_LANES;
  localparam int OFF      = LANE % ROW_LANES;
  localparam int HALF     = ROW_LANES / 2;
  localparam int QPOS     = LANE % 4;
  localparam int QBASE    = LANE - QPOS;
  localparam int HBASE    = LANE - (LANE % HALF);
  localparam int MID      = LANES / 2;

  // source-lane arithmetic, one function so the checker-visible oob wire is explicit
  function automatic int pick_src(input lpu_op_e o, input int n,
                                  input logic [1:0] qf, output logic bad);
    int t;
    bad = 1'b0;
    t   = LANE;
    case (o)
      OP_QUAD:     t = QBASE + int'(qf);
      OP_ROW_UP: begin
        if (OFF + n >= ROW_LANES) bad = 1'b1;
        else                      t = ROW_BASE + OFF + n;
      end
      OP_ROW_DOWN: begin
        if (OFF - n < 0) bad = 1'b1;
        else             t = ROW_BASE + OFF - n;
      end
      OP_ROW_ROT:  t = ROW_BASE + ((OFF - n + ROW_LANES) % ROW_LANES);
      OP_WAVE_UP: begin
        if (LANE == LANES - 1) bad = 1'b1;
        else                   t = LANE + 1;
      end
      OP_WAVE_RUP: t = (LANE + 1) % LANES;
      OP_WAVE_DN: begin
        if (LANE == 0) bad = 1'b1;
        else           t = LANE - 1;
      end
      OP_WAVE_RDN: t = (LANE + LANES - 1) % LANES;
      OP_MIRROR16: t = ROW_BASE + ROW_LANES - 1 - OFF;
      OP_MIRROR8:  t = HBASE + HALF - 1 - (LANE % HALF);
      OP_BC_ROW:   t = (ROW_IDX > 0) ? ROW_BASE - 1 : LANE;
      OP_BC_HALF:  t = (LANE >= MID) ? MID - 1 : LANE;
      default:     t = LANE;
    endcase
    return t;
  endfunction

  logic [IDX_W-1:0] src_idx;
  logic             bad_src;

  always_comb begin
    int s;
    s       = pick_src(op, int'(amount), quad_sel[2*QPOS +: 2], bad_src);
    src_idx = IDX_W'(s);
  end

  assign oob  = bad_src;
  assign data = src_vec[src_idx*WIDTH +: WIDTH];

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lpu_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int WIDTH      = 32,
  parameter int CTRL_W     = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CTRL_W-1:0]        ctrl,
  input  logic [LANES/ROW_LANES-1:0]       row_mask,
  input  logic [ROW_LANES/BANK_LANES-1:0]  bank_mask,
  input  logic                     bound_ctrl,
  input  logic [LANES-1:0]         exec_mask,
  input  logic [LANES*WIDTH-1:0]   src_vec,
  input  logic [LANES*WIDTH-1:0]   old_vec,
  output logic [LANES*WIDTH-1:0]   result_vec,
  output logic [LANES-1:0]         result_we,
  output logic                     ctrl_illegal
);

  localparam int ROWS  = LANES / ROW_LANES;
  localparam int BANKS = ROW_LANES / BANK_LANES;

  lpu_op_e    dec_op;
  logic [3:0] dec_amount;
  logic [7:0] dec_quad;
  logic       dec_illegal;

  lpu_decode u_dec (
    .ctrl     (ctrl),
    .op       (dec_op),
    .amount   (dec_amount),
    .quad_sel (dec_quad),
    .illegal  (dec_illegal)
  );

  // named per-lane events, visible to the bound checker
  logic [LANES-1:0]       lane_en;
  logic [LANES-1:0]       lane_oob;
  logic [LANES-1:0]       next_we;
  logic [LANES*WIDTH-1:0] next_vec;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDTH-1:0] picked;
    logic             invalid_src;

    lpu_lane_sel #(
      .LANES     (LANES),
      .ROW_LANES (ROW_LANES),
      .WIDTH     (WIDTH),
      .LANE      (g)
    ) u_sel (
      .op       (dec_op),
      .amount   (dec_amount),
      .quad_sel (dec_quad),
      .src_vec  (src_vec),
      .oob      (lane_oob[g]),
      .data     (picked)
    );

    assign lane_en[g]   = row_mask[g / ROW_LANES] & bank_mask[(g % ROW_LANES) / BANK_LANES];
    assign invalid_src  = lane_oob[g] | ~exec_mask[g];

    always_comb begin
      next_we[g] = 1'b0;
      next_vec[g*WIDTH +: WIDTH] = old_vec[g*WIDTH +: WIDTH];
      if (!dec_illegal && lane_en[g]) begin
        if (!invalid_src) begin
          next_we[g] = 1'b1;
          next_vec[g*WIDTH +: WIDTH] = picked;
        end else if (bound_ctrl) begin
          next_we[g] = 1'b1;
          next_vec[g*WIDTH +: WIDTH] = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_vec   <= '0;
      result_we    <= '0;
      ctrl_illegal <= 1'b0;
    end else if (in_valid) begin
      result_vec   <= next_vec;
      result_we    <= next_we;
      ctrl_illegal <= dec_illegal;
    end else begin
      result_we    <= '0;
      ctrl_illegal <= 1'b0;
    end
  end

endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
  parameter int LANES = 64,
  parameter int WIDTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [8:0]             ctrl,
  input logic                   bound_ctrl,
  input logic [LANES-1:0]       exec_mask,
  input logic                   dec_illegal,
  input logic [LANES-1:0]       lane_en,
  input logic [LANES-1:0]       lane_oob,
  input logic [LANES-1:0]       result_we,
  input logic [LANES*WIDTH-1:0] result_vec,
  input logic                   ctrl_illegal
);

  // R7: a disabled lane never shows a write enable
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (result_we & ~$past(lane_en)) == '0);

  // R8: bound control 0 leaves lanes with an invalid source unwritten
  p_bc0_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bound_ctrl) |=> (result_we & $past(lane_oob | ~exec_mask)) == '0);

  // R8: bound control 1 writes every enabled lane of a legal operation
  p_bc1_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bound_ctrl && !dec_illegal) |=> result_we == $past(lane_en));

  // R9: an illegal code raises the flag and blocks all writes
  p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_illegal) |=> (ctrl_illegal && result_we == '0));

  // R9: the reserved code is always flagged
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl == 9'h100) |=> ctrl_illegal);

  // R10: idle cycles drop enables and flag, result holds
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (result_we == '0 && !ctrl_illegal && $stable(result_vec)));

endmodule

bind lane_permute_unit lpu_checker #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .ctrl         (ctrl),
  .bound_ctrl   (bound_ctrl),
  .exec_mask    (exec_mask),
  .dec_illegal  (dec_illegal),
  .lane_en      (lane_en),
  .lane_oob     (lane_oob),
  .result_we    (result_we),
  .result_vec   (result_vec),
  .ctrl_illegal (ctrl_illegal)
);

// File: tb/tb_lane_permute_unit.sv
`timescale 1ns/1ps
module tb_lane_permute_unit;

  localparam int L = 64;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [8:0]     ctrl = '0;
  logic [3:0]     row_mask = '0;
  logic [3:0]     bank_mask = '0;
  logic           bound_ctrl = 1'b0;
  logic [L-1:0]   exec_mask = '0;
  logic [L*W-1:0] src_vec = '0;
  logic [L*W-1:0] old_vec = '0;
  logic [L*W-1:0] result_vec;
  logic [L-1:0]   result_we;
  logic           ctrl_illegal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_permute_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
    .row_mask(row_mask), .bank_mask(bank_mask), .bound_ctrl(bound_ctrl),
    .exec_mask(exec_mask), .src_vec(src_vec), .old_vec(old_vec),
    .result_vec(result_vec), .result_we(result_we), .ctrl_illegal(ctrl_illegal)
  );

  // bench model: -1 for illegal code, -2 for out of bounds, else source lane
  function automatic int model_src(input logic [8:0] c, input int d);
    int n, k, rb;
    n  = int'(c[3:0]);
    k  = d % 16;
    rb = d - k;
    if (c < 9'h100) return (d & ~3) + int'((c >> (2 * (d & 3))) & 9'h3);
    if (c >= 9'h101 && c <= 9'h10F) return (k + n > 15) ? -2 : d + n;
    if (c >= 9'h111 && c <= 9'h11F) return (k < n) ? -2 : d - n;
    if (c >= 9'h121 && c <= 9'h12F) return rb + ((k + 16 - n) & 15);
    case (c)
      9'h130: return (d == 63) ? -2 : d + 1;
      9'h134: return (d + 1) & 63;
      9'h138: return (d == 0) ? -2 : d - 1;
      9'h13C: return (d + 63) & 63;
      9'h140: return rb + 15 - k;
      9'h141: return (d & ~7) | (7 - (d & 7));
      9'h142: return (d < 16) ? d : rb - 1;
      9'h143: return (d < 32) ? d : 31;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input logic [8:0] c);
    if (c < 9'h100) return "R1";
    if (model_src(c, 0) == -1) return "R9";
    if (c < 9'h120) return "R2";
    if (c < 9'h130) return "R3";
    if (c < 9'h140) return "R4";
    if (c < 9'h142) return "R5";
    return "R6";
  endfunction

  task automatic check_vec(input string tag, input logic [L*W-1:0] ev,
                           input logic [L-1:0] ew, input logic ei);
    total++;
    if (result_vec !== ev || result_we !== ew || ctrl_illegal !== ei) begin
      bad++;
      $display("FAIL %s ctrl=%h: we=%h exp %h, illegal=%b exp %b, data_match=%b",
               tag, ctrl, result_we, ew, ctrl_illegal, ei, (result_vec === ev));
    end
  endtask

  // drive one strobe, let it be registered, compare against the model (R11 in every case)
  task automatic run_one(input string extra);
    logic [L*W-1:0] ev;
    logic [L-1:0]   ew;
    logic           ei;
    ev = old_vec;
    ew = '0;
    ei = (model_src(ctrl, 0) == -1);
    for (int d = 0; d < L; d++) begin
      int s;
      bit en;
      s  = model_src(ctrl, d);
      en = row_mask[d / 16] && bank_mask[(d % 16) / 4];
      if (!ei && en) begin
        if (s >= 0 && exec_mask[d]) begin
          ew[d] = 1'b1;
          ev[d*W +: W] = src_vec[s*W +: W];
        end else if (bound_ctrl) begin
          ew[d] = 1'b1;
          ev[d*W +: W] = '0;
        end
      end
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec({tag_of(ctrl), extra}, ev, ew, ei);
  endtask

  task automatic rand_data();
    for (int i = 0; i < L; i++) begin
      src_vec[i*W +: W] = $urandom;
      old_vec[i*W +: W] = $urandom;
    end
  endtask

  function automatic logic [8:0] rand_legal();
    int r;
    r = int'($urandom % 8);
    case (r)
      0: return 9'($urandom % 256);
      1: return 9'h100 | 9'(1 + $urandom % 15);
      2: return 9'h110 | 9'(1 + $urandom % 15);
      3: return 9'h120 | 9'(1 + $urandom % 15);
      4: return 9'h130 + 9'(4 * ($urandom % 4));
      5: return 9'h140 + 9'($urandom % 4);
      6: return 9'h101 + 9'($urandom % 2) * 9'h10 + 9'd14;
      default: return 9'h142 + 9'($urandom % 2);
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [L*W-1:0] hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    check_vec("R10 reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: pure routing, all lanes enabled and executing
    row_mask = 4'hF; bank_mask = 4'hF; exec_mask = '1; bound_ctrl = 1'b0;
    foreach (ctrl[i]) ;
    for (int i = 0; i < 12; i++) begin
      logic [8:0] codes [12];
      codes = '{9'h0E4, 9'h01B, 9'h10F, 9'h11F, 9'h12F, 9'h130, 9'h134, 9'h138, 9'h13C, 9'h140, 9'h141, 9'h143};
      rand_data();
      ctrl = codes[i];
      run_one(" directed");
    end
    // R8: edges with bound control 1 write zero, with 0 stay unwritten
    for (int b = 0; b < 2; b++) begin
      bound_ctrl = b[0];
      rand_data(); ctrl = 9'h130; run_one(" R8 edge");
      rand_data(); ctrl = 9'h10F; run_one(" R8 shift15");
      rand_data(); ctrl = 9'h142; exec_mask = 64'h00FF_0000_F0F0_1234; run_one(" R8 exec");
      exec_mask = '1;
    end
    // R7: zero masks write nothing even with bound control 1
    bound_ctrl = 1'b1;
    row_mask = 4'h0; rand_data(); ctrl = 9'h134; run_one(" R7 rows off");
    row_mask = 4'hF; bank_mask = 4'h0; rand_data(); ctrl = 9'h0E4; run_one(" R7 banks off");
    row_mask = 4'h5; bank_mask = 4'hA; rand_data(); ctrl = 9'h121; run_one(" R7 partial");
    // R9: reserved and unlisted codes
    row_mask = 4'hF; bank_mask = 4'hF;
    begin
      logic [8:0] badc [7];
      badc = '{9'h100, 9'h110, 9'h120, 9'h131, 9'h13F, 9'h144, 9'h1FF};
      for (int i = 0; i < 7; i++) begin
        rand_data(); ctrl = badc[i]; run_one(" R9 code");
      end
    end
    // R10: idle cycle keeps result, drops enables and flag
    rand_data(); ctrl = 9'h140; run_one(" R10 pre");
    hold = result_vec;
    rand_data(); ctrl = 9'h100;
    @(negedge clk);
    check_vec("R10 idle", hold, '0, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      rand_data();
      exec_mask  = {$urandom, $urandom} | {$urandom, $urandom};
      row_mask   = 4'($urandom) | 4'($urandom);
      bank_mask  = 4'($urandom) | 4'($urandom);
      bound_ctrl = 1'($urandom);
      ctrl       = (($urandom % 16) == 0) ? 9'($urandom) : rand_legal();
      run_one(" random");
      if (($urandom % 8) == 0) @(negedge clk);
    end
    summary();
  end

endmodule